// File: doc/BRIEF.md
# User RAM Clear Sequencer

This block erases a small battery-backed user RAM on request from an external active-low clear pin. Two control bits, held in an 8-bit control register that the host writes over a simple bus, decide whether the pin does anything at all and whether a finished erase raises an interrupt. When the pin falls while clearing is allowed, the sequencer takes over the single-port RAM write interface. It writes zero to every byte of the 114-byte window, one byte per clock, and then raises a sticky completion flag.

While the sweep runs, a busy output is high and the host's own RAM writes are dropped. While the block is idle, host writes pass straight through to the RAM. The completion flag stays set until the host pulses a read strobe. When the interrupt bit is enabled, the active-low interrupt output is low for as long as the flag is set.

Top module: `ramclr_top`

## Requirements
- R1: After synchronous reset: `busy`=0, `done`=0, `irq_n`=1, `ram_we`=0. Both control bits are cleared.
- R2: A pulse on `ctl_we` captures `ctl_wdata`. Bit 4 is the clear enable and bit 2 is the interrupt enable. The other six bits have no effect.
- R3: `clr_n` passes through a two-flop synchronizer. If it is sampled low at rising edge k after being high, and the clear enable is 1, `busy` rises at edge k+2 and the first write (address 0) is presented in the following cycle.
- R4: A falling edge on `clr_n` while the clear enable is 0 produces no RAM write and leaves `done` at 0.
- R5: A sweep writes data 0x00 to addresses 0, 1, …, 113 in ascending order, one write per clock cycle. That is exactly 114 writes with no gaps.
- R6: `busy` is high in every cycle of the sweep and low otherwise. Host writes are suppressed while `busy` is high. When idle, a host write appears on the RAM port in the same cycle, with the same address and data.
- R7: A sweep starts only on a high-to-low transition. Holding `clr_n` low does not start a second sweep, and neither does a fall during a sweep.
- R8: `done` sets at the edge where `busy` falls and stays set until `done_rd` is sampled high. If the set and the read strobe fall on the same edge, the set wins.
- R9: `irq_n` is low exactly while `done` is 1 and the interrupt enable is 1. With the interrupt enable at 0, `done` still sets but `irq_n` stays high.
- R10: Changing the control bits during a sweep does not stop or shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| clr_n | input | 1 | Asynchronous active-low clear request pin |
| host_we | input | 1 | Host RAM write request |
| host_addr | input | 7 | Host RAM write address |
| host_wdata | input | 8 | Host RAM write data |
| done_rd | input | 1 | Host read strobe that clears the completion flag |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 7 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| busy | output | 1 | High while a sweep is in progress |
| done | output | 1 | Sticky completion flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two events can land on the same edge: the completion flag setting on the last sweep write, and the host's read strobe clearing that flag. The bench watches the RAM port and, in the cycle that presents address 113, raises `done_rd` so that it is sampled on the same edge that ends the sweep. It then expects `done` still high, because the set wins. Host writes attempted during a sweep are a second overlap. A scoreboard that expects only the 114 zero writes judges them, so any leaked host write shows up as a mismatch or an unexpected write.

// File: rtl/ramclr_pkg.sv
package ramclr_pkg;

    parameter int RAM_BYTES   = 114;
    parameter int ADDR_W      = $clog2(RAM_BYTES);
    parameter int DATA_W      = 8;
    parameter int CTL_W       = 8;
    parameter int CLR_EN_BIT  = 4;
    parameter int IRQ_EN_BIT  = 2;
    parameter int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(RAM_BYTES - 1);

    typedef enum logic [0:0] {
        SW_IDLE  = 1'b0,
        SW_SWEEP = 1'b1
    } sweep_state_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ram_wr_t;

    typedef struct packed {
        logic clr_en;
        logic irq_en;
    } ctl_bits_t;

    function automatic logic is_last(input logic [ADDR_W-1:0] a);
        return a == LAST_ADDR;
    endfunction

    function automatic ctl_bits_t decode_ctl(input logic [CTL_W-1:0] w);
        ctl_bits_t c;
        c.clr_en = w[CLR_EN_BIT];
        c.irq_en = w[IRQ_EN_BIT];
        return c;
    endfunction

endpackage

// File: rtl/ramclr_ctl_reg.sv
module ramclr_ctl_reg
    import ramclr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output ctl_bits_t        ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (ctl_we) begin
            ctl <= decode_ctl(ctl_wdata);
        end
    end

endmodule

// File: rtl/ramclr_sync.sv
module ramclr_sync
    import ramclr_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);

    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], pin_n};
        end
    end

    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    assign fall = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/ramclr_sweep.sv
module ramclr_sweep
    import ramclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              finish
);

    sweep_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SW_IDLE;
            addr  <= '0;
        end else begin
            unique case (state)
                SW_IDLE: begin
                    if (start) begin
                        state <= SW_SWEEP;
                        addr  <= '0;
                    end
                end
                SW_SWEEP: begin
                    if (is_last(addr)) begin
                        state <= SW_IDLE;
                        addr  <= '0;
                    end else begin
                        addr <= addr + ADDR_W'(1);
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    assign busy   = (state == SW_SWEEP);
    assign finish = busy & is_last(addr);

endmodule

// File: rtl/ramclr_status.sv
module ramclr_status
    import ramclr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic rd,
    input  logic irq_en,
    output logic done,
    output logic irq_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else if (set) begin
            done <= 1'b1;
        end else if (rd) begin
            done <= 1'b0;
        end
    end

    assign irq_n = ~(done & irq_en);

endmodule

// File: rtl/ramclr_top.sv
module ramclr_top
    import ramclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              clr_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              done_rd,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              busy,
    output logic              done,
    output logic              irq_n
);

    ctl_bits_t         ctl;
    logic              clr_fall;
    logic              sweep_busy;
    logic              sweep_finish;
    logic [ADDR_W-1:0] sweep_addr;
    ram_wr_t           host_wr;
    ram_wr_t           sweep_wr;
    ram_wr_t           port_wr;

    ramclr_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl       (ctl)
    );

    ramclr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (clr_n),
        .fall  (clr_fall)
    );

    ramclr_sweep u_sweep (
        .clk    (clk),
        .rst    (rst),
        .start  (clr_fall & ctl.clr_en),
        .busy   (sweep_busy),
        .addr   (sweep_addr),
        .finish (sweep_finish)
    );

    ramclr_status u_status (
        .clk    (clk),
        .rst    (rst),
        .set    (sweep_finish),
        .rd     (done_rd),
        .irq_en (ctl.irq_en),
        .done   (done),
        .irq_n  (irq_n)
    );

    always_comb begin
        host_wr.we    = host_we;
        host_wr.addr  = host_addr;
        host_wr.data  = host_wdata;
        sweep_wr.we   = 1'b1;
        sweep_wr.addr = sweep_addr;
        sweep_wr.data = '0;
        port_wr       = sweep_busy ? sweep_wr : host_wr;
    end

    assign ram_we    = port_wr.we;
    assign ram_addr  = port_wr.addr;
    assign ram_wdata = port_wr.data;
    assign busy      = sweep_busy;

endmodule

// File: rtl/ramclr_checker.sv
module ramclr_checker
    import ramclr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done_rd,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic              busy,
    input logic              done,
    input logic              irq_n
);

    p_sweep_zero_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ram_we && ram_wdata == '0));

    p_addr_range_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ram_addr <= LAST_ADDR));

    p_first_addr_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (ram_addr == '0));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (ram_addr == ADDR_W'($past(ram_addr) + ADDR_W'(1))));

    p_done_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && $past(ram_addr) == LAST_ADDR));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !done_rd) |=> done);

    p_irq_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> done);

endmodule

bind ramclr_top ramclr_checker u_ramclr_checker (
    .clk       (clk),
    .rst       (rst),
    .done_rd   (done_rd),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .busy      (busy),
    .done      (done),
    .irq_n     (irq_n)
);

// File: tb/test_ramclr_top.sv
module test_ramclr_top;
    import ramclr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_we = 1'b0;
    logic [CTL_W-1:0]  ctl_wdata = '0;
    logic              clr_n = 1'b1;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              done_rd = 1'b0;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic              busy;
    logic              done;
    logic              irq_n;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    logic [ADDR_W+DATA_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    ramclr_top i_ramclr_top (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .clr_n      (clr_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .done_rd    (done_rd),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .busy       (busy),
        .done       (done),
        .irq_n      (irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: compare every RAM write against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && ram_we) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R4/R6/R7 unexpected write actual=%0h/%0h expected=none",
                         ram_addr, ram_wdata);
            end else begin
                check("R5/R6 ram write", {ram_addr, ram_wdata}, exp_q.pop_front());
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_ctl(input logic [CTL_W-1:0] v);
        @(posedge clk); #1;
        ctl_we = 1'b1; ctl_wdata = v;
        @(posedge clk); #1;
        ctl_we = 1'b0;
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        exp_q.push_back({a, d});
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    task automatic push_sweep();
        for (int i = 0; i < RAM_BYTES; i++) exp_q.push_back({ADDR_W'(i), DATA_W'(0)});
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 400) begin
            step(1);
            n++;
        end
    endtask

    task automatic pulse_rd();
        @(posedge clk); #1;
        done_rd = 1'b1;
        @(posedge clk); #1;
        done_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 ram_we", ram_we, 0);

        // R6: idle host writes pass through
        host_write(7'd5, 8'hA5);
        host_write(7'd113, 8'h3C);

        // R2/R4: every bit except the clear enable (bit 4) set: clear ignored
        write_ctl(8'hEF);
        clr_n = 1'b0;
        step(150);
        check("R4 busy stays low", busy, 0);
        check("R4 done stays low", done, 0);
        clr_n = 1'b1;
        step(5);

        // R3/R5/R9: clear with both enables (bits 4 and 2)
        write_ctl(8'h14);
        push_sweep();
        @(posedge clk); #1;
        clr_n = 1'b0;           // sampled low at next edge k
        @(posedge clk); #1;     // after k
        check("R3 busy low after k", busy, 0);
        @(posedge clk); #1;     // after k+1
        check("R3 busy low after k+1", busy, 0);
        @(posedge clk); #1;     // after k+2
        check("R3 busy high after k+2", busy, 1);
        // R6: host write attempts during sweep must be dropped
        host_we = 1'b1; host_addr = 7'd9; host_wdata = 8'hFF;
        step(4);
        host_we = 1'b0;
        check("R6 busy during sweep", busy, 1);
        wait_idle();
        check("R8 done after sweep", done, 1);
        check("R9 irq_n low", irq_n, 0);
        // R7: keep clr_n low, no new sweep
        step(150);
        check("R7 no retrigger", busy, 0);
        check("R5 queue drained", exp_q.size(), 0);
        clr_n = 1'b1;
        step(3);
        check("R8 done sticky", done, 1);
        pulse_rd();
        check("R8 done cleared", done, 0);
        check("R9 irq_n released", irq_n, 1);

        // R9: interrupt disabled, R10: enable dropped mid-sweep, R8 collision
        write_ctl(8'h10);
        push_sweep();
        @(posedge clk); #1;
        clr_n = 1'b0;
        step(10);
        clr_n = 1'b1;
        write_ctl(8'h00);       // R10: clearing enables mid-sweep
        step(3);
        clr_n = 1'b0;           // R7: fall during sweep ignored
        step(3);
        clr_n = 1'b1;
        begin
            int n = 0;
            @(negedge clk);
            while (!(busy && ram_addr == LAST_ADDR) && n < 400) begin
                @(negedge clk);
                n++;
            end
        end
        done_rd = 1'b1;         // sampled on same edge as final write
        @(posedge clk); #1;
        done_rd = 1'b0;
        @(negedge clk);
        check("R8 set wins over read", done, 1);
        check("R10 sweep completed", busy, 0);
        check("R9 irq_n high when disabled", irq_n, 1);
        step(20);
        check("R7/R10 queue drained", exp_q.size(), 0);
        check("R7 no second sweep", busy, 0);
        pulse_rd();
        check("R8 done cleared again", done, 0);

        summary();
    end

endmodule